// File: doc/BRIEF.md
# Program/Erase Completion Status Reporter

This block produces the byte returned on each read while an internally timed byte program or block erase runs. A start strobe begins an operation and captures the byte and address being written. An internal cycle counter sets how long the operation lasts, and a busy flag covers that whole window. When busy falls, a one-cycle completion pulse is raised.

Software can tell that the operation has finished by watching two status bits in the data it reads back:
- The most significant bit (bit 7) reads as the inverse of the written byte's bit 7 while that byte is still being programmed.
- The next bit (bit 6) alternates on every read for as long as the operation runs.

Each bit is an independent completion indicator. Both change only when a read is issued, never when the clock ticks. Once the operation is over, every read returns the array data unchanged. The storage array itself sits outside this block and supplies its data on `array_data`.

A read is the rising edge of `rd_req`. If `rd_req` is held high over several cycles, that still counts as one read. The answer is registered one cycle after the edge and is marked by `rd_valid`.

Top module: `psr_status_reporter`

## Requirements
- R1: After reset, `busy`, `op_done` and `rd_valid` are 0 and `rd_data` is all zeros.
- R2: A start accepted while idle raises `busy` at the next edge. `busy` then stays high for exactly PROG_CYCLES clock cycles for a program (`op_erase`=0) or ERASE_CYCLES clock cycles for an erase (`op_erase`=1). `op_done` is high for one cycle, the first cycle in which `busy` is low again.
- R3: A start presented while `busy` is high is ignored. The running operation keeps its length, kind, captured byte and captured address.
- R4: During a program, a read whose `rd_addr` equals the captured address returns bit 7 equal to the inverse of bit 7 of the captured byte.
- R5: During a program, a read at any other address returns bit 7 of `array_data`. During an erase, bit 7 of every read is 0.
- R6: During either operation, bit 6 of each read is the inverse of bit 6 of the previous status read. The first status read after reset returns bit 6 = 0. The alternation continues across operations without restarting.
- R7: The response is registered at the clock edge where `rd_req` is first seen high. `rd_valid` is high only in the following cycle. Holding `rd_req` high longer produces neither another response nor another bit-6 change.
- R8: During an operation, bits 5..0 of each read equal bits 5..0 of `array_data` at the read edge.
- R9: While idle, all eight bits of each read equal `array_data`, and bit 6 no longer alternates.
- R10: A low `rst_n` during an operation clears `busy` at once. No `op_done` pulse follows for the aborted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when idle |
| op_erase | input | 1 | Operation kind at start: 0 program, 1 erase |
| load_addr | input | ADDR_W | Address of the byte being programmed |
| load_data | input | DATA_W | Byte being programmed |
| rd_req | input | 1 | Read strobe; its rising edge is one read |
| rd_addr | input | ADDR_W | Address of the read |
| array_data | input | DATA_W | Array content at `rd_addr` |
| rd_data | output | DATA_W | Registered read response |
| rd_valid | output | 1 | `rd_data` holds a new response this cycle |
| busy | output | 1 | Operation in progress |
| op_done | output | 1 | One-cycle pulse when an operation ends |

## Verification
Each kind of internal fault shows up at the ports, and usually within one response:

| Internal fault | What the ports show | How soon |
|---|---|---|
| Wrong cycle count in the timer | `busy` falls one or more cycles early or late; the `op_done` pulse moves with it | At the end of the operation |
| Flip-flop behind bit 6 advances on a level instead of an edge | Bit 6 of the next status read disagrees with the alternating sequence | Next status read |
| Flip-flop behind bit 6 advances while idle | Bit 6 of the next status read disagrees with the alternating sequence | Next status read |
| Captured address or byte is overwritten by a start during busy | Bit 7 of the next read at the original address is wrong | Next such read |
| Operation kind is mixed up | Bit 7 comes out wrong during erase polling | Next status read |
| Operation kind is mixed up | The length of `busy` is wrong | At the end of the operation |

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_kind_e;

  // Number of busy cycles for one operation kind.
  function automatic int op_cycles(op_kind_e kind, int prog_len, int erase_len);
    return (kind == OP_ERASE) ? erase_len : prog_len;
  endfunction

endpackage

// File: rtl/psr_op_timer.sv
module psr_op_timer
  import psr_pkg::*;
#(
  parameter int PROG_CYCLES  = 30,
  parameter int ERASE_CYCLES = 300
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     op_erase,
  output logic     busy,
  output logic     accept,
  output logic     done,
  output op_kind_e kind
);
  localparam int MAX_LEN = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] left;
  op_kind_e         req_kind;
  logic             expire;

  assign req_kind = op_erase ? OP_ERASE : OP_PROG;
  assign accept   = start & ~busy;
  assign expire   = busy & (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
      kind <= OP_PROG;
      done <= 1'b0;
    end else begin
      done <= expire;
      if (accept) begin
        busy <= 1'b1;
        kind <= req_kind;
        left <= CNT_W'(op_cycles(req_kind, PROG_CYCLES, ERASE_CYCLES) - 1);
      end else if (expire) begin
        busy <= 1'b0;
      end else if (busy) begin
        left <= left - 1'b1;
      end
    end
  end

  AST_ACCEPT_RAISES: assert property (@(posedge clk) disable iff (!rst_n) accept |=> busy); // R2
  AST_EXPIRE_ENDS: assert property (@(posedge clk) disable iff (!rst_n) expire |=> (!busy && done)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (busy && !expire) |=> (busy && $stable(kind))); // R3

endmodule

// File: rtl/psr_read_edge.sv
module psr_read_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_req,
  output logic rd_rise
);
  logic rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_req;
  end

  assign rd_rise = rd_req & ~rd_q;

  AST_ONE_READ_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n) rd_rise |=> !rd_rise); // R7

endmodule

// File: rtl/psr_status_gen.sv
module psr_status_gen
  import psr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_rise,
  input  logic              busy,
  input  op_kind_e          kind,
  input  logic              addr_hit,
  input  logic              loaded_msb,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TGL_BIT  = DATA_W - 2;

  logic              tgl;
  logic [DATA_W-1:0] resp_w;

  function automatic logic [DATA_W-1:0] compose(
    logic [DATA_W-1:0] arr, logic in_op, op_kind_e k,
    logic hit, logic msb, logic t);
    logic [DATA_W-1:0] r;
    r = arr;
    if (in_op) begin
      r[TGL_BIT] = t;
      if (k == OP_ERASE) r[POLL_BIT] = 1'b0;
      else if (hit)      r[POLL_BIT] = ~msb;
    end
    return r;
  endfunction

  assign resp_w = compose(array_data, busy, kind, addr_hit, loaded_msb, tgl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl      <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_rise;
      if (rd_rise) begin
        rd_data <= resp_w;
        if (busy) tgl <= ~tgl;
      end
    end
  end

  AST_TGL_ON_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (tgl != $past(tgl)) |-> $past(rd_rise && busy)); // R6
  AST_TGL_REPORTED: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && $past(busy)) |-> (rd_data[TGL_BIT] != tgl)); // R6
  AST_POLL_INVERTS: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && $past(busy && kind == OP_PROG && addr_hit)) |-> (rd_data[POLL_BIT] == ~$past(loaded_msb))); // R4
  AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && $past(busy)) |-> (rd_data[TGL_BIT-1:0] == $past(array_data[TGL_BIT-1:0]))); // R8
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && !$past(busy)) |-> (rd_data == $past(array_data))); // R9

endmodule

// File: rtl/psr_status_reporter.sv
module psr_status_reporter
  import psr_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 30,
  parameter int ERASE_CYCLES = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_erase,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              op_done
);
  logic              accept;
  logic              rd_rise;
  logic              addr_hit;
  op_kind_e          kind;
  logic [ADDR_W-1:0] addr_q;
  logic              msb_q;

  psr_op_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .busy(busy), .accept(accept), .done(op_done), .kind(kind)
  );

  psr_read_edge u_edge (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_rise(rd_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      msb_q  <= 1'b0;
    end else if (accept) begin
      addr_q <= load_addr;
      msb_q  <= load_data[DATA_W-1];
    end
  end

  assign addr_hit = (rd_addr == addr_q);

  psr_status_gen #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst_n(rst_n), .rd_rise(rd_rise), .busy(busy), .kind(kind),
    .addr_hit(addr_hit), .loaded_msb(msb_q), .array_data(array_data),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> ($stable(addr_q) && $stable(msb_q))); // R3
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) op_done |-> (!busy && $past(busy))); // R2

endmodule

// File: tb/tb_psr_status_reporter.sv
module tb_psr_status_reporter;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int PC = 30;
  localparam int EC = 300;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, start, op_erase, rd_req;
  logic [AW-1:0] load_addr, rd_addr;
  logic [DW-1:0] load_data, array_data;
  wire  [DW-1:0] rd_data;
  wire           rd_valid, busy, op_done;

  psr_status_reporter #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .load_addr(load_addr), .load_data(load_data), .rd_req(rd_req),
    .rd_addr(rd_addr), .array_data(array_data), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy), .op_done(op_done)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  string ph = "";

  // expectation state, kept from the requirements
  bit m_busy, m_erase, m_d7, m_tgl, m_prev, m_valid, m_done;
  int m_left;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_rd;
  string m_c7, m_c6, m_clo;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    bit rise;
    rise = rst_n && rd_req && !m_prev;
    if (!rst_n) begin
      m_busy = 0; m_tgl = 0; m_prev = 0; m_valid = 0; m_done = 0; m_rd = '0; m_left = 0;
    end else begin
      m_prev  = rd_req;
      m_valid = rise;
      if (rise) begin
        m_rd = array_data; m_c7 = "R9"; m_c6 = "R9"; m_clo = "R9";
        if (m_busy) begin
          m_rd[6] = m_tgl; m_tgl = !m_tgl; m_c6 = "R6"; m_clo = "R8";
          if (m_erase) begin m_rd[7] = 1'b0; m_c7 = "R5"; end
          else if (rd_addr == m_addr) begin m_rd[7] = !m_d7; m_c7 = "R4"; end
          else m_c7 = "R5";
        end
      end
      m_done = m_busy && (m_left == 0);
      if (m_busy) begin
        if (m_left == 0) m_busy = 0; else m_left--;
      end else if (start) begin
        m_busy = 1; m_erase = op_erase; m_left = (op_erase ? EC : PC) - 1;
        m_d7 = load_data[7]; m_addr = load_addr;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk({ph, "/R2 busy"}, busy, m_busy);
    chk({ph, "/R2 op_done"}, op_done, m_done);
    chk({ph, "/R7 rd_valid"}, rd_valid, m_valid);
    if (m_valid) begin
      chk({ph, "/", m_c7, " bit7"}, rd_data[7], m_rd[7]);
      chk({ph, "/", m_c6, " bit6"}, rd_data[6], m_rd[6]);
      chk({ph, "/", m_clo, " bits5_0"}, rd_data[5:0], m_rd[5:0]);
    end
  endtask

  task automatic rd_pulse(logic [AW-1:0] a, int hold);
    rd_addr = a;
    rd_req  = 1'b1;
    for (int i = 0; i < hold; i++) step();
    rd_req = 1'b0;
    step();
  endtask

  task automatic launch(bit erase, logic [AW-1:0] a, logic [DW-1:0] d);
    start = 1'b1; op_erase = erase; load_addr = a; load_data = d;
    step();
    start = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; start = 0; op_erase = 0; rd_req = 0;
    load_addr = '0; load_data = '0; rd_addr = '0; array_data = '0;
    @(negedge clk);
    ph = "R1";
    repeat (3) step();
    chk("R1 busy", busy, 0); chk("R1 rd_valid", rd_valid, 0);
    chk("R1 op_done", op_done, 0); chk("R1 rd_data", rd_data, 0);
    rst_n = 1;
    step();

    // program, poll its own address (bit7 of 0x5A is 0, so poll reads 1)
    ph = "R4"; array_data = 8'hFF;
    launch(1'b0, 17'h01234, 8'h5A);
    for (int i = 0; i < 3; i++) rd_pulse(17'h01234, 1);
    ph = "R7"; rd_pulse(17'h01234, 6);
    ph = "R5"; array_data = 8'hB1; rd_pulse(17'h00777, 1);
    ph = "R8"; array_data = 8'h2D; rd_pulse(17'h01234, 1);
    // start while busy must leave the capture alone
    ph = "R3"; launch(1'b1, 17'h00055, 8'hC3);
    rd_pulse(17'h01234, 1);
    while (m_busy) step();
    chk("R3 busy after program length", busy, 0);
    ph = "R9";
    for (int i = 0; i < 4; i++) begin array_data = 8'(8'h40 + i); rd_pulse(17'h01234, 1); end

    // erase with reads held and short
    ph = "R5"; array_data = 8'hFF;
    launch(1'b1, 17'h1C000, 8'h00);
    for (int i = 0; i < 5; i++) rd_pulse(17'h1C002, (i % 3) + 1);
    while (m_busy) begin rd_pulse(17'h1C002, 2); end
    ph = "R9"; rd_pulse(17'h1C002, 1);

    // program of a byte whose bit7 is 1, poll reads 0
    ph = "R4"; array_data = 8'hFF;
    launch(1'b0, 17'h00010, 8'h80);
    rd_pulse(17'h00010, 1); rd_pulse(17'h00010, 1);
    while (m_busy) step();

    // abort by reset
    ph = "R10";
    launch(1'b0, 17'h00020, 8'h11);
    repeat (5) step();
    rst_n = 0; #1;
    chk("R10 busy cleared at reset", busy, 0);
    step();
    rst_n = 1;
    for (int i = 0; i < PC + 5; i++) begin
      step();
      chk("R10 no op_done after abort", op_done, 0);
    end

    // constrained random traffic
    ph = "RND";
    for (int i = 0; i < 6000; i++) begin
      start      = ($urandom % 40) == 0;
      op_erase   = ($urandom % 5) == 0;
      load_addr  = AW'($urandom);
      load_data  = DW'($urandom);
      rd_req     = ($urandom % 3) == 0;
      rd_addr    = (($urandom % 2) == 0) ? m_addr : AW'($urandom);
      array_data = DW'($urandom);
      step();
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule